// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block is a slave on a two-wire serial bus (clock line and data line, both open-drain). It runs on a fast system clock and samples both lines through synchronizers. It finds START and STOP conditions and answers only to one fixed 7-bit device address. It turns bus transfers into single-cycle read and write requests on a plain register-file port. An 8-bit byte pointer selects the register. In a write transfer, the first byte after the control byte sets the pointer. The pointer then moves up by one for every data byte, in both directions.

A register read may take several system cycles. While it is waiting for the data, the slave holds the clock line low to stretch the transfer. After the data arrives, it drives the first bit and waits a few setup cycles before it lets the clock line go. A typical host first writes the pointer, then issues a repeated START with the read direction, and then streams bytes. It acknowledges every byte except the last, which it NACKs before the STOP.

Top module: `twi_reg_slave`

## Requirements
- R1: On a synchronous reset the slave releases both lines (`sda_oe`=0, `scl_oe`=0), issues no register request and clears the byte pointer to 0. A read with no pointer set first therefore starts at register 0.
- R2: After a START, a first byte whose upper seven bits are 1010000 is acknowledged: the slave pulls SDA low during the ninth clock. Bit 0 of that byte selects the direction: 1 is read, 0 is write.
- R3: A first byte with any other address gets no acknowledge. The slave then drives nothing and requests nothing until the next START, so SDA reads 1 on every later bit.
- R4: In a write transfer, the first byte after the control byte loads the pointer. That byte and every later data byte are acknowledged (SDA low on the ninth clock).
- R5: Each later written byte produces one `reg_wr` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increments and wraps from 0xFF to 0x00.
- R6: All bytes are shifted most significant bit first, in both directions.
- R7: In a read transfer, the slave returns the register at the pointer and then increments the pointer. A master ACK (SDA low) fetches the next byte. A master NACK (SDA high) ends the read, and the slave releases SDA.
- R8: For every read fetch the slave holds SCL low until `reg_rvalid` arrives. It starts holding SCL only while SCL is already low, and holds SCL in no other situation.
- R9: START and STOP are SDA edges while SCL is high. A repeated START in the middle of a byte discards that partial byte and restarts address decoding; the pointer is kept.
- R10: The slave changes `sda_oe` only while SCL is low.
- R11: A reset asserted in the middle of a transfer returns the slave to idle, with both lines released at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK or data 0) |
| reg_addr | output | AW | Register index for a read or write request |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | One-cycle read request |
| reg_rdata | input | 8 | Read data, valid with `reg_rvalid` |
| reg_rvalid | input | 1 | Read data return strobe, at least one cycle after `reg_rd` |

## Verification
The assertions check the line-discipline rules on every cycle:
- the data enable never moves while the synchronized clock is high;
- a stretch starts only from a low clock, and is held only while a fetch is pending;
- a START always lands in address decoding with both lines free;
- nothing is driven while the slave is idle or ignoring the bus;
- write strobes last one cycle.

Only the bench scenarios can show the rest, because it depends on whole transfers:
- which byte values land at which register indices, and that the pointer wraps;
- that a foreign address is ignored;
- that a partial byte before a repeated START is discarded;
- what is read back after a reset in the middle of a transfer.

// File: rtl/twi_regs_pkg.sv
package twi_regs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_FETCH,
    ST_SETUP,
    ST_SHIFT,
    ST_MACK,
    ST_SKIP
  } twi_state_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic r;
      always_ff @(posedge clk) begin
        if (rst) r <= 1'b1;
        else     r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk) begin
        if (rst) r <= '1;
        else     r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/twi_bus_cond.sv
module twi_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    // data edges are conditions only when the clock is high on both samples
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_regs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'b1010000,
  parameter int         AW        = 8,
  parameter int         SETUP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic [AW-1:0]     reg_addr,
  output logic              reg_wr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_rdata,
  input  logic              reg_rvalid,
  output twi_state_e        state
);
  localparam int CW = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;

  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [AW-1:0]     ptr;
  logic              rw;
  logic              more;
  logic [CW-1:0]     cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      ptr       <= '0;
      rw        <= 1'b0;
      more      <= 1'b0;
      cnt       <= '0;
      sda_oe    <= 1'b0;
      scl_oe    <= 1'b0;
      reg_addr  <= '0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      reg_rd    <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= 4'd9;
              if (state == ST_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_PTR) begin
                ptr    <= shreg[AW-1:0];
                sda_oe <= 1'b1;
              end else begin
                reg_addr  <= ptr;
                reg_wdata <= shreg;
                reg_wr    <= 1'b1;
                ptr       <= ptr + 1'b1;
                sda_oe    <= 1'b1;
              end
            end else if (scl_fall && bitcnt == 4'd9) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (rw) begin
                  state    <= ST_FETCH;
                  reg_addr <= ptr;
                  reg_rd   <= 1'b1;
                  scl_oe   <= 1'b1;
                end else begin
                  state <= ST_PTR;
                end
              end else begin
                state <= ST_WDATA;
              end
            end
          end
          ST_FETCH: begin
            if (reg_rvalid && !reg_rd) begin
              shreg  <= reg_rdata;
              sda_oe <= ~reg_rdata[BYTE_W-1];
              ptr    <= ptr + 1'b1;
              cnt    <= '0;
              state  <= ST_SETUP;
            end
          end
          ST_SETUP: begin
            if (cnt == CW'(SETUP_CYC - 1)) begin
              scl_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_SHIFT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_SHIFT: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
              end else begin
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~shreg[BYTE_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              more <= ~sda_s;
            end else if (scl_fall) begin
              if (more) begin
                state    <= ST_FETCH;
                reg_addr <= ptr;
                reg_rd   <= 1'b1;
                scl_oe   <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
  import twi_regs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1010000,
  parameter int         AW          = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         SETUP_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [AW-1:0]     reg_addr,
  output logic              reg_wr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_rdata,
  input  logic              reg_rvalid
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  twi_state_e st;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst(rst), .d(scl_i), .q(scl_s)
  );
  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst(rst), .d(sda_i), .q(sda_s)
  );

  twi_bus_cond u_cond (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_slave_fsm #(
    .DEV_ADDR(DEV_ADDR), .AW(AW), .SETUP_CYC(SETUP_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .scl_oe(scl_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .state(st)
  );
endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk
  import twi_regs_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       reg_wr,
  input logic       start_det,
  input twi_state_e st
);
  p_stretch_from_low_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe) |-> !$past(scl_s));

  p_stretch_only_fetch_r8: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> (st == ST_FETCH || st == ST_SETUP));

  p_sda_quiet_high_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(scl_s)) |-> $stable(sda_oe));

  p_start_restarts_r9: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (st == ST_ADDR && !sda_oe && !scl_oe));

  p_skip_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SKIP || st == ST_IDLE) |-> (!sda_oe && !scl_oe));

  p_wr_single_r5: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);
endmodule

bind twi_reg_slave twi_reg_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .reg_wr(reg_wr), .start_det(start_det), .st(st)
);

// File: tb/sim_twi_reg_slave.sv
`timescale 1ns/1ps
module sim_twi_reg_slave;
  localparam int H = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic scl_m, sda_m;
  logic scl_oe, sda_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic reg_wr, reg_rd, reg_rvalid;
  wire  scl_bus = scl_m & ~scl_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  twi_reg_slave u0 (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
  );

  int n_cmp = 0, n_bad = 0;

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 29) + 7);
  endfunction

  // register file model with variable read latency
  logic [7:0] rf [256];
  logic [7:0] raddr;
  logic       pend;
  int         lat, wr_count = 0;
  always @(posedge clk) begin
    reg_rvalid <= 1'b0;
    if (rst) begin
      for (int i = 0; i < 256; i++) rf[i] <= init_val(i);
      pend <= 1'b0;
      reg_rdata <= 8'h00;
    end else begin
      if (reg_wr) begin
        rf[reg_addr] <= reg_wdata;
        wr_count <= wr_count + 1;
      end
      if (reg_rd) begin
        pend  <= 1'b1;
        lat   <= 1 + int'($urandom % 6);
        raddr <= reg_addr;
      end else if (pend) begin
        if (lat == 0) begin
          reg_rvalid <= 1'b1;
          reg_rdata  <= rf[raddr];
          pend       <= 1'b0;
        end else lat <= lat - 1;
      end
    end
  end

  // line discipline monitors
  int stretch_cyc = 0, stretch_viol = 0, sda_viol = 0;
  logic p_scloe = 1'b0, p_sdaoe = 1'b0, p_sclbus = 1'b1, p_rst = 1'b1;
  always @(negedge clk) begin
    if (!rst && !p_rst) begin
      if (scl_oe) stretch_cyc <= stretch_cyc + 1;
      if (scl_oe && !p_scloe && p_sclbus) stretch_viol <= stretch_viol + 1;
      if (p_sclbus && scl_bus && sda_oe != p_sdaoe) sda_viol <= sda_viol + 1;
    end
    p_scloe  <= scl_oe;
    p_sdaoe  <= sda_oe;
    p_sclbus <= scl_bus;
    p_rst    <= rst;
  end

  logic [7:0] gm [256];
  logic [7:0] dbuf [8];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clk_pulse(output logic s);
    scl_m = 1'b1;
    while (!scl_bus) tick(1);
    tick(H / 2);
    s = sda_bus;
    tick(H / 2);
    scl_m = 1'b0;
    tick(2);
  endtask

  task automatic t_start();
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1;
    while (!scl_bus) tick(1);
    tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic t_stop();
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1;
    while (!scl_bus) tick(1);
    tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    logic s;
    for (int i = 7; i >= 8 - n; i--) begin
      sda_m = b[i];
      tick(H);
      clk_pulse(s);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1;
    tick(H);
    clk_pulse(ack);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(H);
      clk_pulse(s);
      b = {b[6:0], s};
    end
    sda_m = ~mack;
    tick(H);
    clk_pulse(s);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] p, input int n);
    logic a;
    t_start();
    send_byte(8'hA0, a); chk(a == 1'b0, "R2 ctrl ack", a, 0);
    send_byte(p, a);     chk(a == 1'b0, "R4 ptr ack", a, 0);
    for (int i = 0; i < n; i++) begin
      send_byte(dbuf[i], a);
      chk(a == 1'b0, "R4 data ack", a, 0);
      gm[8'(p + i)] = dbuf[i];
    end
    t_stop();
    tick(4);
  endtask

  task automatic do_read(input logic [7:0] p, input int n);
    logic a;
    logic [7:0] b;
    t_start();
    send_byte(8'hA0, a);
    send_byte(p, a);
    t_start();  // repeated START, R9
    send_byte(8'hA1, a); chk(a == 1'b0, "R2 read ctrl ack", a, 0);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(b == gm[8'(p + i)], "R7 R6 read data", b, gm[8'(p + i)]);
    end
    t_stop();
    tick(4);
    chk(!sda_oe && !scl_oe, "R7 release after NACK", {sda_oe, scl_oe}, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(3);
    chk(!sda_oe && !scl_oe && !reg_wr && !reg_rd, "R1 R11 reset outputs",
        {sda_oe, scl_oe, reg_wr, reg_rd}, 0);
    scl_m = 1'b1; sda_m = 1'b1;
    tick(3);
    rst = 1'b0;
    for (int i = 0; i < 256; i++) gm[i] = init_val(i);
    tick(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] b;
    int wc;
    void'($urandom(32'd4242));
    scl_m = 1'b1; sda_m = 1'b1; rst = 1'b1;
    tick(2);
    do_reset();

    // R1: pointer is 0 after reset, current-address read
    t_start();
    send_byte(8'hA1, a); chk(a == 1'b0, "R2 ack", a, 0);
    recv_byte(1'b0, b);  chk(b == gm[0], "R1 ptr zero read", b, gm[0]);
    t_stop(); tick(4);

    // directed write and read-back with asymmetric bytes (R5 R6)
    dbuf[0] = 8'h12; dbuf[1] = 8'h80; dbuf[2] = 8'h01;
    do_write(8'h10, 3);
    for (int i = 0; i < 3; i++)
      chk(rf[8'h10 + i] == dbuf[i], "R5 R6 reg write", rf[8'h10 + i], dbuf[i]);
    do_read(8'h0F, 5);
    chk(stretch_cyc > 0, "R8 stretch seen", stretch_cyc, 1);

    // foreign address (R3)
    wc = wr_count;
    t_start();
    send_byte(8'hA2, a); chk(a == 1'b1, "R3 no ack", a, 1);
    send_byte(8'h20, a); chk(a == 1'b1, "R3 ignored byte", a, 1);
    send_byte(8'h00, a); chk(a == 1'b1, "R3 ignored byte", a, 1);
    t_stop(); tick(4);
    chk(wr_count == wc, "R3 no write", wr_count, wc);
    t_start();
    send_byte(8'hA3, a); chk(a == 1'b1, "R3 no ack read", a, 1);
    recv_byte(1'b0, b);  chk(b == 8'hFF, "R3 bus idle", b, 8'hFF);
    t_stop(); tick(4);

    // pointer wrap (R5)
    dbuf[0] = 8'hC4; dbuf[1] = 8'h3B;
    do_write(8'hFF, 2);
    chk(rf[255] == 8'hC4, "R5 write at FF", rf[255], 8'hC4);
    chk(rf[0] == 8'h3B, "R5 wrap to 00", rf[0], 8'h3B);

    // repeated START in the middle of a data byte (R9)
    wc = wr_count;
    t_start();
    send_byte(8'hA0, a);
    send_byte(8'h40, a);
    send_bits(8'hAB, 3);
    t_start();
    send_byte(8'hA1, a); chk(a == 1'b0, "R9 restart ack", a, 0);
    recv_byte(1'b0, b);  chk(b == gm[8'h40], "R9 ptr kept", b, gm[8'h40]);
    t_stop(); tick(4);
    chk(wr_count == wc, "R9 partial byte dropped", wr_count, wc);

    // reset during a read (R11)
    t_start();
    send_byte(8'hA0, a);
    send_byte(8'h30, a);
    t_start();
    send_byte(8'hA1, a);
    recv_byte(1'b1, b);
    do_reset();
    t_start();
    send_byte(8'hA1, a);
    recv_byte(1'b0, b);  chk(b == gm[0], "R11 idle after reset", b, gm[0]);
    t_stop(); tick(4);

    // random write/read-back (R4 R5 R7)
    for (int it = 0; it < 25; it++) begin
      logic [7:0] p;
      int n;
      p = 8'($urandom);
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
      do_write(p, n);
      do_read(p, n);
    end

    chk(stretch_viol == 0, "R8 stretch began with SCL high", stretch_viol, 0);
    chk(sda_viol == 0, "R10 SDA moved while SCL high", sda_viol, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule